// File: doc/BRIEF.md
# Codec-link raw interrupt status register

This block holds seven sticky raw status flags for the control and GPIO slots of an AC'97-style serial codec link. Software reads them as one read-only 32-bit word on a simple register bus. The frame engine sends single-cycle event strobes into the block: a slot finished transmitting, slot data arrived, the codec reported ready, a wake-up was detected, and the slot-12 GPIO bit was captured. The bus side sends strobes for writes to the slot 1, 2 and 12 data registers, for reads of the slot 2 and slot 12 data registers, and for writes to an end-of-interrupt register.

Each flag has its own set and clear rule. Some flags clear when new transmit data is written. Some clear when a receive register is read. Some clear only through the end-of-interrupt register. The wake-up, GPIO-interrupt and codec-ready flags are ORed into a registered raw interrupt line.

All pins are plain control and status pins. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `codec_irq_status`

## Requirements
- R1: A synchronous active-high reset clears every flag, the whole status word and the interrupt output to zero.
- R2: The status word carries the flags in these bit positions: 0 slot-1 transmit done, 1 slot-2 receive valid, 2 GPIO transmit done, 3 GPIO interrupt, 4 wake-up, 5 codec ready, 6 slot-2 transmit done. Bits 31..7 always read zero. A flag changes on the clock edge that samples its strobe, and it holds when none of its strobes is active.
- R3: Slot-1 transmit done sets on the slot-1 transmit-done strobe and clears on a write to the slot-1 data register.
- R4: Slot-2 transmit done sets on the slot-2 transmit-done strobe and clears on a write to the slot-2 data register.
- R5: GPIO transmit done sets on the slot-12 transmit-done strobe and clears on a write to the slot-12 data register.
- R6: Slot-2 receive valid sets on the slot-2 receive strobe and clears on a read of the slot-2 data register.
- R7: On a slot-12 capture strobe, the GPIO interrupt flag loads the captured GPIO bit. A read of the slot-12 data register clears it.
- R8: The wake-up flag sets on the wake-up strobe and clears on any write to the end-of-interrupt register.
- R9: Codec ready sets on the ready strobe only when the wake-up flag is already set or the wake-up strobe arrives in the same cycle. It clears only on an end-of-interrupt write whose data bit 1 is 1.
- R10: When a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R11: The interrupt output equals the OR of status bits 3, 4 and 5 as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s1_tx_done | input | 1 | Slot-1 transmission finished |
| s2_tx_done | input | 1 | Slot-2 transmission finished |
| s12_tx_done | input | 1 | Slot-12 transmission finished |
| s2_rx_strobe | input | 1 | Slot-2 data received |
| s12_cap_strobe | input | 1 | Slot-12 receive value captured |
| s12_gpio_bit | input | 1 | Captured slot-12 bit 0 |
| ready_seen | input | 1 | Slot-0 ready bit seen in a received frame |
| wake_strobe | input | 1 | Wake-up detected |
| wr_s1_data | input | 1 | Bus write to slot-1 data register |
| wr_s2_data | input | 1 | Bus write to slot-2 data register |
| wr_s12_data | input | 1 | Bus write to slot-12 data register |
| rd_s2_data | input | 1 | Bus read of slot-2 data register |
| rd_s12_data | input | 1 | Bus read of slot-12 data register |
| eoi_write | input | 1 | Bus write to end-of-interrupt register |
| eoi_data_b1 | input | 1 | Bit 1 of that write's data |
| status_word | output | 32 | Raw status register value |
| irq_raw | output | 1 | Registered OR of the interrupt flags |

## Verification
The assertions check three things on every cycle for every flag: a set wins over a clear, a lone clear lowers the flag, and the flag holds when nothing touches it. They also check that the interrupt line follows the previous cycle's interrupt flags.

Only the bench's scenarios can show the rest. That covers which strobe drives which flag and which bit each flag lands in. It also covers the wake-up gating of codec ready, the need for data bit 1 to clear codec ready, and the loading of GPIO interrupt from the captured bit. The bench checks these with a behavioural model that it compares on every clock.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int NFLAG  = 7;
  localparam int B_S1TX = 0;
  localparam int B_S2RX = 1;
  localparam int B_GTX  = 2;
  localparam int B_GINT = 3;
  localparam int B_WAKE = 4;
  localparam int B_RDY  = 5;
  localparam int B_S2TX = 6;
  localparam logic [NFLAG-1:0] IRQ_MASK =
    (NFLAG'(1) << B_GINT) | (NFLAG'(1) << B_WAKE) | (NFLAG'(1) << B_RDY);
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/cirq_flag.sv
module cirq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!set_i && clr_i) |=> !q_o);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/cirq_event_map.sv
module cirq_event_map
  import cirq_pkg::*;
(
  input  logic      s1_tx_done,
  input  logic      s2_tx_done,
  input  logic      s12_tx_done,
  input  logic      s2_rx_strobe,
  input  logic      s12_cap_strobe,
  input  logic      s12_gpio_bit,
  input  logic      ready_seen,
  input  logic      wake_strobe,
  input  logic      wr_s1_data,
  input  logic      wr_s2_data,
  input  logic      wr_s12_data,
  input  logic      rd_s2_data,
  input  logic      rd_s12_data,
  input  logic      eoi_write,
  input  logic      eoi_data_b1,
  input  logic      wake_q,
  output flag_vec_t set_v,
  output flag_vec_t clr_v
);
  always_comb begin
    set_v = '0;
    clr_v = '0;
    // transmit-done flags: cleared by new transmit data (R3, R4, R5)
    set_v[B_S1TX] = s1_tx_done;
    clr_v[B_S1TX] = wr_s1_data;
    set_v[B_S2TX] = s2_tx_done;
    clr_v[B_S2TX] = wr_s2_data;
    set_v[B_GTX]  = s12_tx_done;
    clr_v[B_GTX]  = wr_s12_data;
    // receive valid: cleared by a read (R6)
    set_v[B_S2RX] = s2_rx_strobe;
    clr_v[B_S2RX] = rd_s2_data;
    // GPIO interrupt loads the captured bit (R7)
    set_v[B_GINT] = s12_cap_strobe & s12_gpio_bit;
    clr_v[B_GINT] = rd_s12_data | (s12_cap_strobe & ~s12_gpio_bit);
    // wake-up (R8)
    set_v[B_WAKE] = wake_strobe;
    clr_v[B_WAKE] = eoi_write;
    // codec ready, only inside a wake-up (R9)
    set_v[B_RDY]  = ready_seen & (wake_q | wake_strobe);
    clr_v[B_RDY]  = eoi_write & eoi_data_b1;
  end
endmodule

// File: rtl/cirq_irq_reg.sv
module cirq_irq_reg #(
  parameter int W = 7,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags_i,
  output logic         irq_o
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      irq_o   <= |(flags_i & MASK);
      past_ok <= 1'b1;
    end
  end

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (irq_o == $past(|(flags_i & MASK))));
endmodule

// File: rtl/codec_irq_status.sv
module codec_irq_status
  import cirq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_tx_done,
  input  logic              s2_tx_done,
  input  logic              s12_tx_done,
  input  logic              s2_rx_strobe,
  input  logic              s12_cap_strobe,
  input  logic              s12_gpio_bit,
  input  logic              ready_seen,
  input  logic              wake_strobe,
  input  logic              wr_s1_data,
  input  logic              wr_s2_data,
  input  logic              wr_s12_data,
  input  logic              rd_s2_data,
  input  logic              rd_s12_data,
  input  logic              eoi_write,
  input  logic              eoi_data_b1,
  output logic [WORD_W-1:0] status_word,
  output logic              irq_raw
);
  localparam int RSV_W = WORD_W - NFLAG;

  flag_vec_t set_v, clr_v, flags;

  cirq_event_map u_map (
    .s1_tx_done    (s1_tx_done),
    .s2_tx_done    (s2_tx_done),
    .s12_tx_done   (s12_tx_done),
    .s2_rx_strobe  (s2_rx_strobe),
    .s12_cap_strobe(s12_cap_strobe),
    .s12_gpio_bit  (s12_gpio_bit),
    .ready_seen    (ready_seen),
    .wake_strobe   (wake_strobe),
    .wr_s1_data    (wr_s1_data),
    .wr_s2_data    (wr_s2_data),
    .wr_s12_data   (wr_s12_data),
    .rd_s2_data    (rd_s2_data),
    .rd_s12_data   (rd_s12_data),
    .eoi_write     (eoi_write),
    .eoi_data_b1   (eoi_data_b1),
    .wake_q        (flags[B_WAKE]),
    .set_v         (set_v),
    .clr_v         (clr_v)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    cirq_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .set_i(set_v[i]),
      .clr_i(clr_v[i]),
      .q_o  (flags[i])
    );
  end

  cirq_irq_reg #(.W(NFLAG), .MASK(IRQ_MASK)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .flags_i(flags),
    .irq_o  (irq_raw)
  );

  assign status_word = {{RSV_W{1'b0}}, flags};
endmodule

// File: tb/tb_codec_irq_status.sv
`timescale 1ns/1ps
module tb_codec_irq_status;
  logic clk = 1'b0;
  logic rst;
  logic [14:0] stim;
  logic [31:0] status_word;
  logic irq_raw;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_flag[7];
  int m_irq;
  int seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  codec_irq_status dut (
    .clk(clk), .rst(rst),
    .s1_tx_done(stim[0]), .s2_tx_done(stim[1]), .s12_tx_done(stim[2]),
    .s2_rx_strobe(stim[3]), .s12_cap_strobe(stim[4]), .s12_gpio_bit(stim[5]),
    .ready_seen(stim[6]), .wake_strobe(stim[7]),
    .wr_s1_data(stim[8]), .wr_s2_data(stim[9]), .wr_s12_data(stim[10]),
    .rd_s2_data(stim[11]), .rd_s12_data(stim[12]),
    .eoi_write(stim[13]), .eoi_data_b1(stim[14]),
    .status_word(status_word), .irq_raw(irq_raw)
  );

  function automatic string req_of(int b);
    case (b)
      0: return "R3";
      1: return "R6";
      2: return "R5";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int b = 0; b < 7; b++) chk(req_of(b), int'(status_word[b]), m_flag[b]);
    chk("R2", int'(status_word[31:7]), 0);
    chk("R11", int'(irq_raw), m_irq);
  endtask

  function automatic int nxt(int q, int s, int c);
    if (s != 0) return 1;
    if (c != 0) return 0;
    return q;
  endfunction

  // one cycle: check at negedge, drive, advance the model past the next posedge
  task automatic cyc(logic [14:0] s);
    int set_r;
    @(negedge clk);
    if (!rst) compare_all();
    stim = s;
    if (rst) begin
      for (int b = 0; b < 7; b++) m_flag[b] = 0;
      m_irq = 0;
    end else begin
      m_irq = (m_flag[3] | m_flag[4] | m_flag[5]) != 0 ? 1 : 0;
      set_r = s[6] & (m_flag[4] != 0 || s[7]) ? 1 : 0;
      m_flag[0] = nxt(m_flag[0], s[0], s[8]);
      m_flag[6] = nxt(m_flag[6], s[1], s[9]);
      m_flag[2] = nxt(m_flag[2], s[2], s[10]);
      m_flag[1] = nxt(m_flag[1], s[3], s[11]);
      m_flag[3] = nxt(m_flag[3], s[4] & s[5], s[12] | (s[4] & ~s[5]));
      m_flag[5] = nxt(m_flag[5], set_r, s[13] & s[14]);
      m_flag[4] = nxt(m_flag[4], s[7], s[13]);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc('0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    stim = '0;
    rst = 1'b1;
    cyc('0); cyc('0);
    rst = 1'b0;
    // R1: reset state
    @(negedge clk);
    chk("R1", int'(status_word), 0);
    chk("R1", int'(irq_raw), 0);
    idle(1);
    // R3 R4 R5 R6 set then clear
    cyc(15'h000F); idle(2);
    cyc(15'h0100); cyc(15'h0200); cyc(15'h0400); cyc(15'h0800); idle(2);
    // R9: ready without wake is ignored
    cyc(15'h0040); idle(2);
    @(negedge clk);
    chk("R9", int'(status_word[5]), 0);
    // R8 + R9: wake then ready
    cyc(15'h0080); cyc(15'h0040); idle(3);
    // R9: EOI without bit1 clears wake only
    cyc(15'h2000); idle(2);
    @(negedge clk);
    chk("R9", int'(status_word[5]), 1);
    chk("R8", int'(status_word[4]), 0);
    cyc(15'h6000); idle(2);
    // R9: ready with wake in same cycle
    cyc(15'h00C0); idle(2);
    cyc(15'h6000);
    // R7: capture 1, capture 0, capture 1 then read
    cyc(15'h0030); idle(2); cyc(15'h0010); idle(2);
    cyc(15'h0030); idle(1); cyc(15'h1000); idle(2);
    // R10: set and clear together
    cyc(15'h0101); idle(1);
    @(negedge clk);
    chk("R10", int'(status_word[0]), 1);
    cyc(15'h1030); idle(1);
    @(negedge clk);
    chk("R10", int'(status_word[3]), 1);
    // mixed random traffic compared each clock
    for (int i = 0; i < 3000; i++) begin
      logic [14:0] s;
      s = '0;
      for (int b = 0; b < 15; b++) s[b] = ($urandom(seed) % 5) == 0;
      seed = seed + 1;
      cyc(s);
      if (i == 1500) begin
        rst = 1'b1; cyc('0); rst = 1'b0;
      end
    end
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule